// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller of an integrating dual-slope converter. It steps the analog front end through four phases: auto-zero, signal integrate, reference integrate and integrator zero. It drives one switch-control output per phase, with the reference switch split by input polarity. While the reference is integrated it counts clocks in decimal. The count stops when the registered comparator reports that the integrator has crossed zero, or when full scale is exceeded.

At the end of each conversion the block presents a BCD reading, a sign bit, and over-scale and under-scale flags for range switching. It also gives a one-cycle load strobe for the result register, and a busy output that covers the two integration phases. The run input selects free-running or single-shot operation. The analog parts and the display scan belong to other blocks.

Phase lengths are parameters. At the defaults the auto-zero (10,001 clocks), signal-integrate (10,000 clocks) and longest reference-integrate (20,001 clocks) phases add up to 40,002 clocks. The integrator-zero phase follows them.

Top module: `dsadc_seq`

## Requirements
- R1: The phases follow the order auto-zero (AZ_LEN clocks) → signal integrate (SI_LEN clocks) → reference integrate → integrator zero. Exactly one of the five switch outputs is high in every cycle, and after reset busy first rises AZ_LEN clocks after reset is released.
- R2: At the end of integrator zero, a high run_i starts the next auto-zero at once. A low run_i enters a hold state: sw_az_o is high, busy_o is low and the result stays unchanged for as long as run_i stays low.
- R3: In the hold state, a high level on run_i starts exactly one conversion, and busy_o rises AZ_LEN+1 clocks after the cycle in which run_i was driven high. A run_i pulse that arrives while a conversion is in progress after run_i went low has no effect once that conversion ends.
- R4: busy_o is high only during signal integrate and reference integrate, never during auto-zero. It falls on the first clock after a sampled zc_i. If zc_i is high in reference-integrate cycle k (cycle 0 is the first), busy_o is high for SI_LEN+k+1 clocks.
- R5: The count is held during the first reference-integrate cycle and then advances once per cycle until zc_i is sampled high. A crossing in cycle k≥1 therefore reads k−1.
- R6: If no crossing arrives within RI_MAX = 2·10^(NDIG−1)+1 reference cycles, the phase ends and overrange_o is set when busy_o falls, with a reading of zero. overrange_o clears at the start of the next reference-integrate phase and keeps its value through the auto-zero and signal-integrate phases before it.
- R7: underrange_o is set when busy_o falls if the reading is UR_LIMIT or less and there is no overrange. It clears at the start of the next signal-integrate phase, and it is never high together with overrange_o.
- R8: polarity_o takes cmp_pos_i from the last signal-integrate cycle (1 = positive input), including for a zero reading. It changes only at the start of reference integrate, where it selects sw_ri_pos_o (1) or sw_ri_neg_o (0).
- R9: Integrator zero lasts IZ_LEN clocks, or IZ_OVR_LEN clocks after an overrange.
- R10: load_o is high for the single first cycle after busy_o falls, and result_o takes the count at the end of that cycle and changes at no other time. result_o holds NDIG BCD digits with the least significant digit in bits [3:0], and its top digit is 0 or 1.
- R11: A synchronous active-high reset selects auto-zero, clears busy_o, polarity_o, overrange_o, underrange_o and load_o, and sets result_o to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | 1 = free-running, 0 = hold after the current conversion; a high level in hold starts one conversion |
| cmp_pos_i | input | 1 | Comparator sign at the end of signal integrate, 1 = positive |
| zc_i | input | 1 | Registered zero-crossing indication during reference integrate |
| sw_az_o | output | 1 | Auto-zero switch control (also held in hold state) |
| sw_si_o | output | 1 | Signal-integrate switch control |
| sw_ri_pos_o | output | 1 | Reference switch for a positive input |
| sw_ri_neg_o | output | 1 | Reference switch for a negative input |
| sw_iz_o | output | 1 | Integrator-zero switch control |
| busy_o | output | 1 | High through both integration phases |
| polarity_o | output | 1 | Sign of the last conversion, 1 = positive |
| overrange_o | output | 1 | Last reading exceeded full scale |
| underrange_o | output | 1 | Last reading at or below UR_LIMIT |
| load_o | output | 1 | One-cycle result-register load strobe |
| result_o | output | 4*NDIG | BCD reading, digit 0 in bits [3:0] |

## Verification
On every clock the assertions check that exactly one phase switch is on and that busy never overlaps auto-zero. They also check the moments at which the sign and both range flags may change, that the result changes only after the load strobe, and the cap on the top digit. Only the bench scenarios can show the numeric relation between crossing time and reading, including the one-count hold at the start of reference integrate. The same holds for the busy and integrator-zero lengths, the underrange boundary at UR_LIMIT and the overrange wrap to zero, and the difference between free-running, hold and single-shot operation.

// File: rtl/dsadc_pkg.sv
`timescale 1ns/1ps
package dsadc_pkg;

    typedef enum logic [2:0] {
        PH_AZ   = 3'd0,
        PH_SI   = 3'd1,
        PH_RI   = 3'd2,
        PH_IZ   = 3'd3,
        PH_HOLD = 3'd4
    } phase_e;

    function automatic int unsigned pow10(input int unsigned n);
        int unsigned r;
        r = 1;
        for (int unsigned i = 0; i < n; i++) r = r * 10;
        return r;
    endfunction

    function automatic logic [63:0] bin2bcd(input int unsigned v);
        logic [63:0] r;
        int unsigned t;
        r = '0;
        t = v;
        for (int i = 0; i < 16; i++) begin
            r[4*i +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

endpackage

// File: rtl/dsadc_phase_timer.sv
`timescale 1ns/1ps
module dsadc_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    output logic [W-1:0] cnt_o
);

    always_ff @(posedge clk) begin
        if (rst || clr) cnt_o <= '0;
        else            cnt_o <= cnt_o + 1'b1;
    end

endmodule

// File: rtl/dsadc_bcd_counter.sv
`timescale 1ns/1ps
module dsadc_bcd_counter #(
    parameter int NDIG = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            en,
    output logic [4*NDIG-1:0] cnt_o,
    output logic            wrap_o
);

    logic [NDIG:0] carry;
    assign carry[0] = en;

    generate
        for (genvar g = 0; g < NDIG; g++) begin : g_dig
            localparam logic [3:0] LIM = (g == NDIG - 1) ? 4'd1 : 4'd9;
            logic [3:0] d_q;
            logic       at_lim;

            assign at_lim       = (d_q == LIM);
            assign carry[g + 1] = carry[g] && at_lim;

            always_ff @(posedge clk) begin
                if (rst || clr)    d_q <= 4'd0;
                else if (carry[g]) d_q <= at_lim ? 4'd0 : d_q + 4'd1;
            end

            assign cnt_o[4*g +: 4] = d_q;
        end
    endgenerate

    assign wrap_o = carry[NDIG];

endmodule

// File: rtl/dsadc_flags.sv
`timescale 1ns/1ps
module dsadc_flags #(
    parameter int              RW     = 20,
    parameter logic [RW-1:0]   UR_BCD = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          si_start,
    input  logic          ri_start,
    input  logic          ri_end,
    input  logic          ovr_hit,
    input  logic          load,
    input  logic          cmp_pos_i,
    input  logic [RW-1:0] count_i,
    output logic          pol_o,
    output logic          ovr_o,
    output logic          ur_o,
    output logic [RW-1:0] result_o
);

    // BCD values order like unsigned binary, so a plain compare suffices
    always_ff @(posedge clk) begin
        if (rst) begin
            pol_o    <= 1'b0;
            ovr_o    <= 1'b0;
            ur_o     <= 1'b0;
            result_o <= '0;
        end else begin
            if (si_start) ur_o <= 1'b0;
            if (ri_start) begin
                pol_o <= cmp_pos_i;
                ovr_o <= 1'b0;
            end
            if (ri_end) begin
                ovr_o <= ovr_hit;
                ur_o  <= !ovr_hit && (count_i <= UR_BCD);
            end
            if (load) result_o <= count_i;
        end
    end

endmodule

// File: rtl/dsadc_seq.sv
`timescale 1ns/1ps
module dsadc_seq
    import dsadc_pkg::*;
#(
    parameter int unsigned NDIG       = 5,
    parameter int unsigned AZ_LEN     = 10001,
    parameter int unsigned SI_LEN     = 10000,
    parameter int unsigned IZ_LEN     = 150,
    parameter int unsigned IZ_OVR_LEN = 6200,
    parameter int unsigned UR_LIMIT   = 1800
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  logic              cmp_pos_i,
    input  logic              zc_i,
    output logic              sw_az_o,
    output logic              sw_si_o,
    output logic              sw_ri_pos_o,
    output logic              sw_ri_neg_o,
    output logic              sw_iz_o,
    output logic              busy_o,
    output logic              polarity_o,
    output logic              overrange_o,
    output logic              underrange_o,
    output logic              load_o,
    output logic [4*NDIG-1:0] result_o
);

    localparam int unsigned RW     = 4 * NDIG;
    localparam int unsigned FS     = 2 * pow10(NDIG - 1);
    localparam int unsigned RI_MAX = FS + 1;
    localparam int unsigned M1     = (AZ_LEN > SI_LEN) ? AZ_LEN : SI_LEN;
    localparam int unsigned M2     = (IZ_LEN > IZ_OVR_LEN) ? IZ_LEN : IZ_OVR_LEN;
    localparam int unsigned M3     = (M1 > M2) ? M1 : M2;
    localparam int unsigned TMAX   = (M3 > RI_MAX) ? M3 : RI_MAX;
    localparam int unsigned TW     = $clog2(TMAX + 1);
    localparam logic [RW-1:0] UR_BCD = RW'(bin2bcd(UR_LIMIT));

    phase_e        state_q, state_d;
    logic [TW-1:0] tmr;
    logic [RW-1:0] count;
    logic          wrap;
    logic          ri_first, cnt_en;
    logic          si_start, ri_start, ri_end;
    logic [TW-1:0] iz_last;

    dsadc_phase_timer #(.W(TW)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clr   (state_d != state_q),
        .cnt_o (tmr)
    );

    assign ri_first = (state_q == PH_RI) && (tmr == '0);
    assign cnt_en   = (state_q == PH_RI) && !ri_first && !zc_i;

    dsadc_bcd_counter #(.NDIG(NDIG)) u_count (
        .clk    (clk),
        .rst    (rst),
        .clr    (ri_start),
        .en     (cnt_en),
        .cnt_o  (count),
        .wrap_o (wrap)
    );

    assign si_start = (state_q == PH_AZ) && (state_d == PH_SI);
    assign ri_start = (state_q == PH_SI) && (state_d == PH_RI);
    assign ri_end   = (state_q == PH_RI) && (state_d == PH_IZ);
    assign iz_last  = overrange_o ? TW'(IZ_OVR_LEN - 1) : TW'(IZ_LEN - 1);

    dsadc_flags #(.RW(RW), .UR_BCD(UR_BCD)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .si_start  (si_start),
        .ri_start  (ri_start),
        .ri_end    (ri_end),
        .ovr_hit   (wrap),
        .load      (load_o),
        .cmp_pos_i (cmp_pos_i),
        .count_i   (count),
        .pol_o     (polarity_o),
        .ovr_o     (overrange_o),
        .ur_o      (underrange_o),
        .result_o  (result_o)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= PH_AZ;
        else     state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_AZ:   if (tmr == TW'(AZ_LEN - 1)) state_d = PH_SI;
            PH_SI:   if (tmr == TW'(SI_LEN - 1)) state_d = PH_RI;
            PH_RI:   if (zc_i || wrap)           state_d = PH_IZ;
            PH_IZ:   if (tmr == iz_last)         state_d = run_i ? PH_AZ : PH_HOLD;
            PH_HOLD: if (run_i)                  state_d = PH_AZ;
            default:                             state_d = PH_AZ;
        endcase
    end

    // Outputs decoded from the registered state
    always_comb begin
        sw_az_o     = 1'b0;
        sw_si_o     = 1'b0;
        sw_ri_pos_o = 1'b0;
        sw_ri_neg_o = 1'b0;
        sw_iz_o     = 1'b0;
        busy_o      = 1'b0;
        load_o      = 1'b0;
        unique case (state_q)
            PH_AZ, PH_HOLD: sw_az_o = 1'b1;
            PH_SI: begin
                sw_si_o = 1'b1;
                busy_o  = 1'b1;
            end
            PH_RI: begin
                sw_ri_pos_o = polarity_o;
                sw_ri_neg_o = !polarity_o;
                busy_o      = 1'b1;
            end
            PH_IZ: begin
                sw_iz_o = 1'b1;
                load_o  = (tmr == '0);
            end
            default: sw_az_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/dsadc_seq_chk.sv
`timescale 1ns/1ps
module dsadc_seq_chk #(
    parameter int RW = 20
) (
    input logic          clk,
    input logic          rst,
    input logic          sw_az_o,
    input logic          sw_si_o,
    input logic          sw_ri_pos_o,
    input logic          sw_ri_neg_o,
    input logic          sw_iz_o,
    input logic          busy_o,
    input logic          polarity_o,
    input logic          overrange_o,
    input logic          underrange_o,
    input logic          load_o,
    input logic [RW-1:0] result_o
);

    AST_ONE_SWITCH: assert property (@(posedge clk) disable iff (rst)
        $countones({sw_az_o, sw_si_o, sw_ri_pos_o, sw_ri_neg_o, sw_iz_o}) == 1); // R1
    AST_SI_FROM_AZ: assert property (@(posedge clk) disable iff (rst)
        $rose(sw_si_o) |-> $past(sw_az_o)); // R1
    AST_IZ_FROM_RI: assert property (@(posedge clk) disable iff (rst)
        $rose(sw_iz_o) |-> $past(sw_ri_pos_o || sw_ri_neg_o)); // R1
    AST_BUSY_NOT_AZ: assert property (@(posedge clk) disable iff (rst)
        sw_az_o |-> !busy_o); // R4
    AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (rst)
        busy_o == (sw_si_o || sw_ri_pos_o || sw_ri_neg_o)); // R4
    AST_OVR_EDGES: assert property (@(posedge clk) disable iff (rst)
        !$stable(overrange_o) |-> ($fell(busy_o) || $rose(sw_ri_pos_o || sw_ri_neg_o))); // R6
    AST_UR_EDGES: assert property (@(posedge clk) disable iff (rst)
        !$stable(underrange_o) |-> ($fell(busy_o) || $rose(sw_si_o))); // R7
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(overrange_o && underrange_o)); // R7
    AST_POL_EDGE: assert property (@(posedge clk) disable iff (rst)
        !$stable(polarity_o) |-> $rose(sw_ri_pos_o || sw_ri_neg_o)); // R8
    AST_LOAD_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        load_o |-> $fell(busy_o)); // R10
    AST_RESULT_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
        !$stable(result_o) |-> $past(load_o)); // R10
    AST_TOP_DIGIT: assert property (@(posedge clk) disable iff (rst)
        result_o[RW-1 -: 4] <= 4'd1); // R10

endmodule

bind dsadc_seq dsadc_seq_chk #(.RW(RW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .sw_az_o      (sw_az_o),
    .sw_si_o      (sw_si_o),
    .sw_ri_pos_o  (sw_ri_pos_o),
    .sw_ri_neg_o  (sw_ri_neg_o),
    .sw_iz_o      (sw_iz_o),
    .busy_o       (busy_o),
    .polarity_o   (polarity_o),
    .overrange_o  (overrange_o),
    .underrange_o (underrange_o),
    .load_o       (load_o),
    .result_o     (result_o)
);

// File: tb/dsadc_seq_tb.sv
`timescale 1ns/1ps
module dsadc_seq_tb;

    localparam int NDIG   = 3;
    localparam int AZ     = 101;
    localparam int SI     = 100;
    localparam int IZ     = 15;
    localparam int IZO    = 62;
    localparam int UR     = 18;
    localparam int RI_MAX = 201;
    localparam int RW     = 4 * NDIG;

    logic clk = 1'b0;
    logic rst, run_i, cmp_pos_i, zc_i;
    logic sw_az_o, sw_si_o, sw_ri_pos_o, sw_ri_neg_o, sw_iz_o;
    logic busy_o, polarity_o, overrange_o, underrange_o, load_o;
    logic [RW-1:0] result_o;

    int checks = 0;
    int errors = 0;
    bit last_ovr = 1'b0;

    typedef struct {
        int reading;
        bit ovr;
        bit ur;
        bit pol;
        int busy_len;
        int iz_len;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    dsadc_seq #(
        .NDIG(NDIG), .AZ_LEN(AZ), .SI_LEN(SI), .IZ_LEN(IZ),
        .IZ_OVR_LEN(IZO), .UR_LIMIT(UR)
    ) u_dut (
        .clk(clk), .rst(rst), .run_i(run_i), .cmp_pos_i(cmp_pos_i), .zc_i(zc_i),
        .sw_az_o(sw_az_o), .sw_si_o(sw_si_o), .sw_ri_pos_o(sw_ri_pos_o),
        .sw_ri_neg_o(sw_ri_neg_o), .sw_iz_o(sw_iz_o), .busy_o(busy_o),
        .polarity_o(polarity_o), .overrange_o(overrange_o),
        .underrange_o(underrange_o), .load_o(load_o), .result_o(result_o)
    );

    function automatic int to_bcd(input int v);
        int r, t;
        r = 0;
        t = v;
        for (int i = 0; i < NDIG; i++) begin
            r = r | ((t % 10) << (4 * i));
            t = t / 10;
        end
        return r;
    endfunction

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Driver: one conversion; k = cycle of the crossing in reference integrate, 0 = none
    task automatic convert(input int k, input bit pos);
        exp_t e;
        while (!busy_o) @(negedge clk);
        cmp_pos_i = pos;
        chk_eq("R7", "underrange cleared in SI", int'(underrange_o), 0);
        chk_eq("R6", "overrange kept through SI", int'(overrange_o), int'(last_ovr));
        e.reading  = (k > 0) ? k - 1 : 0;
        e.ovr      = (k == 0);
        e.ur       = !e.ovr && (e.reading <= UR);
        e.pol      = pos;
        e.busy_len = (k > 0) ? SI + k + 1 : SI + RI_MAX;
        e.iz_len   = e.ovr ? IZO : IZ;
        sb.push_back(e);
        last_ovr = e.ovr;
        while (!(sw_ri_pos_o || sw_ri_neg_o)) @(negedge clk);
        chk_eq("R8", "reference switch by sign", int'(sw_ri_pos_o), int'(pos));
        chk_eq("R6", "overrange cleared at RI start", int'(overrange_o), 0);
        if (k > 0) begin
            repeat (k) @(negedge clk);
            zc_i = 1'b1;
            @(negedge clk);
            zc_i = 1'b0;
        end else begin
            while (busy_o) @(negedge clk);
        end
    endtask

    task automatic idle_check(input int n, input int exp_res);
        bit ok;
        ok = 1'b1;
        while (sw_iz_o) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            if (busy_o || !sw_az_o || int'(result_o) != exp_res) ok = 1'b0;
            @(negedge clk);
        end
        chk_eq("R2", "hold keeps idle and result", int'(ok), 1);
    endtask

    // Monitor: pops an expected item at each busy fall
    initial begin
        int bcnt;
        bit prev;
        int iz;
        exp_t e;
        bcnt = 0;
        prev = 1'b0;
        forever begin
            @(negedge clk);
            if (rst) begin
                bcnt = 0;
                prev = 1'b0;
            end else if (busy_o) begin
                bcnt++;
                prev = 1'b1;
            end else if (prev) begin
                prev = 1'b0;
                if (sb.size() == 0) begin
                    chk_eq("R4", "unexpected conversion", 0, 1);
                end else begin
                    e = sb.pop_front();
                    chk_eq("R4", "busy length", bcnt, e.busy_len);
                    chk_eq("R6", "overrange at busy fall", int'(overrange_o), int'(e.ovr));
                    chk_eq("R7", "underrange at busy fall", int'(underrange_o), int'(e.ur));
                    chk_eq("R10", "load strobe after fall", int'(load_o), 1);
                    iz = 1;
                    @(negedge clk);
                    chk_eq("R5", "reading", int'(result_o), to_bcd(e.reading));
                    chk_eq("R8", "polarity", int'(polarity_o), int'(e.pol));
                    chk_eq("R10", "load one cycle", int'(load_o), 0);
                    while (sw_iz_o) begin
                        iz++;
                        @(negedge clk);
                    end
                    chk_eq("R9", "integrator zero length", iz, e.iz_len);
                end
                bcnt = 0;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        rst = 1'b1;
        run_i = 1'b1;
        cmp_pos_i = 1'b0;
        zc_i = 1'b0;
        repeat (3) @(negedge clk);
        chk_eq("R11", "reset auto-zero switch", int'(sw_az_o), 1);
        chk_eq("R11", "reset busy", int'(busy_o), 0);
        chk_eq("R11", "reset flags", int'({polarity_o, overrange_o, underrange_o, load_o}), 0);
        chk_eq("R11", "reset result", int'(result_o), 0);
        rst = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!busy_o);
        chk_eq("R1", "auto-zero length to busy", n, AZ);

        convert(1, 1'b0);    // zero reading, negative
        convert(1, 1'b1);    // zero reading, positive
        convert(19, 1'b1);   // 18: underrange boundary
        convert(20, 1'b0);   // 19: just above
        convert(124, 1'b1);  // 123
        convert(200, 1'b0);  // 199: largest in range
        convert(0, 1'b1);    // overrange
        convert(57, 1'b1);   // 56 after overrange

        // Drop run during a conversion, with an ignored pulse in it (R3)
        while (!busy_o) @(negedge clk);
        run_i = 1'b0;
        @(negedge clk);
        run_i = 1'b1;
        @(negedge clk);
        run_i = 1'b0;
        convert(40, 1'b1);
        idle_check(3 * AZ, to_bcd(39));

        // Single shot from hold (R3)
        run_i = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            run_i = 1'b0;
        end while (!busy_o);
        chk_eq("R3", "single shot starts with auto-zero", n, AZ + 1);
        convert(90, 1'b0);
        idle_check(2 * AZ, to_bcd(89));

        chk_eq("R10", "all conversions observed", sb.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule